// File: doc/BRIEF.md
# Sleep and Wake Controller

This block decides when a small processor core stops its clock and when the clock starts again. The pipeline raises a wait-for-interrupt request or a wait-for-event request. The controller then drops the core clock-gate enable and holds it low until a wake condition for that kind of sleep appears. At that point it raises the enable again and gives a single-cycle wake pulse on the same edge.

The two sleep kinds wake on different sets of sources. Wait-for-interrupt wakes on:
- a taken exception,
- any pending, enabled line that could preempt, whatever PRIMASK holds,
- any debug entry request.

Wait-for-event wakes on:
- a taken exception,
- a pending, enabled, preemption-eligible line, but only while PRIMASK is clear,
- a local send-event or an external event,
- a debug request, but only while debug is enabled,
- an enabled line that newly becomes pending, when the pend-as-event control bit is set.

A one-bit sticky event latch records events that arrive while the core is not sleeping on them. A later wait-for-event uses up the latch and does not sleep. Priority arbitration, vectoring and deeper power modes are handled elsewhere.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: During and after reset the event latch is 0, the core is awake, coreClkEn is 1 and wakePulse is 0.
- R2: A wait-for-event request that arrives while the core is awake, with the event latch at 1 or with sevLocal or evIn high in the same cycle, clears the latch and completes without sleeping: coreClkEn stays 1.
- R3: A wait-for-event request that arrives while the core is awake, with the latch at 0 and no event in that cycle, drops coreClkEn on the next clock edge. coreClkEn stays 0 until a wait-for-event wake source is seen.
- R4: While in wait-for-event sleep, the core wakes on any of these: excTaken; a line with pending, enable and preempt all 1 while primask is 0; sevLocal; evIn; dbgReq while dbgEn is 1; or, while sevOnPend is 1, a newly pending enabled line.
- R5: While in wait-for-event sleep, the core stays asleep on any of these alone: dbgReq with dbgEn at 0; a preemptable pending line with primask at 1; a newly pending enabled line that is not preemptable, with sevOnPend at 0.
- R6: While in wait-for-interrupt sleep, the core wakes on excTaken, on dbgReq whatever dbgEn holds, and on any line with pending, enable and preempt all 1 whatever primask holds.
- R7: While in wait-for-interrupt sleep, sevLocal and evIn do not wake the core, but they set the event latch.
- R8: sevLocal or evIn while the core is awake, and not consumed by a wait-for-event in that cycle, sets the event latch. Events seen during wait-for-event sleep are consumed by the wake and are not latched.
- R9: A wake raises coreClkEn and pulses wakePulse high for exactly one cycle, both on the same clock edge.
- R10: Sleep requests are ignored while asleep. If both requests arrive together while awake, the core enters wait-for-interrupt sleep.
- R11: A line is newly pending when its pending-and-enabled value is 1 and was 0 at the previous clock edge. A line that stays pending across the sleep entry does not count as new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Active-low synchronous reset |
| wfiReq | input | 1 | Wait-for-interrupt request from the pipeline |
| wfeReq | input | 1 | Wait-for-event request from the pipeline |
| irqPending | input | NUM_IRQ | Per-line pending flags |
| irqEnable | input | NUM_IRQ | Per-line enable flags |
| irqPreempt | input | NUM_IRQ | Per-line flag: the line could preempt the current level |
| excTaken | input | 1 | Strobe: an exception has been taken |
| sevLocal | input | 1 | Send-event strobe from the local core |
| evIn | input | 1 | Event input from peripherals or other processors |
| dbgReq | input | 1 | Debug entry request |
| dbgEn | input | 1 | Debug enabled |
| sevOnPend | input | 1 | Treat a newly pending line as an event |
| primask | input | 1 | Interrupt mask bit |
| coreClkEn | output | 1 | Core clock-gate enable, low while asleep |
| wakePulse | output | 1 | One-cycle pulse on each wake |

## Verification
The assertions assume that all inputs are known and settled at each rising edge. They also assume that reset is held low for at least one edge before requests begin. They treat the sleep request lines as sampled levels, so a request held for several cycles is legal, and once the core sleeps the extra cycles are ignored. The stimulus changes inputs only just after an edge. It keeps pending vectors changing slowly, so that both held lines and newly pending lines occur, and it mixes in directed sequences for each wake source and each masked source.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;

  typedef enum logic [1:0] {
    S_AWAKE = 2'd0,
    S_WFI   = 2'd1,
    S_WFE   = 2'd2
  } sleepState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setEvent;
    logic clrEvent;
  } ctrlStrobes_t;

endpackage

// File: rtl/slpwk_datapath.sv
module slpwk_datapath
  import slpwk_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqPending,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic [NUM_IRQ-1:0] irqPreempt,
  input  logic               excTaken,
  input  logic               sevLocal,
  input  logic               evIn,
  input  logic               dbgReq,
  input  logic               dbgEn,
  input  logic               sevOnPend,
  input  logic               primask,
  input  ctrlStrobes_t       strobes,
  output logic               eventQ,
  output logic               eventNow,
  output logic               wakeWfi,
  output logic               wakeWfe
);

  logic [NUM_IRQ-1:0] maskedQ;
  logic [NUM_IRQ-1:0] risePend;
  logic [NUM_IRQ-1:0] preemptOk;

  // per-line edge detect and preemption eligibility
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) maskedQ[i] <= 1'b0;
      else       maskedQ[i] <= irqPending[i] & irqEnable[i];
    end
    assign risePend[i]  = irqPending[i] & irqEnable[i] & ~maskedQ[i];
    assign preemptOk[i] = irqPending[i] & irqEnable[i] & irqPreempt[i];
  end

  logic anyPreempt;
  logic anyRise;
  assign anyPreempt = |preemptOk;
  assign anyRise    = |risePend;
  assign eventNow   = sevLocal | evIn;

  // PRIMASK deliberately ignored for the interrupt-wait flavour
  assign wakeWfi = excTaken | anyPreempt | dbgReq;
  assign wakeWfe = excTaken | (anyPreempt & ~primask) | eventNow |
                   (dbgReq & dbgEn) | (sevOnPend & anyRise);

  always_ff @(posedge clk) begin
    if (!rstN)                 eventQ <= 1'b0;
    else if (strobes.clrEvent) eventQ <= 1'b0;
    else if (strobes.setEvent) eventQ <= 1'b1;
  end

  assert_latch_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrEvent |=> !eventQ);

  assert_latch_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setEvent && !strobes.clrEvent) |=> eventQ);

endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl
  import slpwk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wfiReq,
  input  logic         wfeReq,
  input  logic         eventQ,
  input  logic         eventNow,
  input  logic         wakeWfi,
  input  logic         wakeWfe,
  output ctrlStrobes_t strobes,
  output logic         coreClkEn,
  output logic         wakePulse
);

  sleepState_e state, stateNext;
  logic        wakeNext;

  always_comb begin
    stateNext = state;
    wakeNext  = 1'b0;
    strobes   = '0;
    unique case (state)
      S_AWAKE: begin
        if (wfiReq) begin
          stateNext        = S_WFI;
          strobes.setEvent = eventNow;
        end else if (wfeReq) begin
          if (eventQ || eventNow) strobes.clrEvent = 1'b1;
          else                    stateNext        = S_WFE;
        end else begin
          strobes.setEvent = eventNow;
        end
      end
      S_WFI: begin
        strobes.setEvent = eventNow;
        if (wakeWfi) begin
          stateNext = S_AWAKE;
          wakeNext  = 1'b1;
        end
      end
      S_WFE: begin
        if (wakeWfe) begin
          stateNext = S_AWAKE;
          wakeNext  = 1'b1;
        end
      end
      default: stateNext = S_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_AWAKE;
      wakePulse <= 1'b0;
    end else begin
      state     <= stateNext;
      wakePulse <= wakeNext;
    end
  end

  assign coreClkEn = (state == S_AWAKE);

  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  assert_wake_with_clock_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn) |-> wakePulse);

  assert_sleep_needs_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreClkEn) |-> $past(wfiReq || wfeReq));

  assert_wfi_latches_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WFI && eventNow && !wakeWfi) |=> (!coreClkEn && eventQ));

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import slpwk_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wfiReq,
  input  logic               wfeReq,
  input  logic [NUM_IRQ-1:0] irqPending,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic [NUM_IRQ-1:0] irqPreempt,
  input  logic               excTaken,
  input  logic               sevLocal,
  input  logic               evIn,
  input  logic               dbgReq,
  input  logic               dbgEn,
  input  logic               sevOnPend,
  input  logic               primask,
  output logic               coreClkEn,
  output logic               wakePulse
);

  ctrlStrobes_t strobes;
  logic eventQ, eventNow, wakeWfi, wakeWfe;

  slpwk_datapath #(.NUM_IRQ(NUM_IRQ)) u_dp (
    .clk(clk), .rstN(rstN),
    .irqPending(irqPending), .irqEnable(irqEnable), .irqPreempt(irqPreempt),
    .excTaken(excTaken), .sevLocal(sevLocal), .evIn(evIn),
    .dbgReq(dbgReq), .dbgEn(dbgEn), .sevOnPend(sevOnPend), .primask(primask),
    .strobes(strobes), .eventQ(eventQ), .eventNow(eventNow),
    .wakeWfi(wakeWfi), .wakeWfe(wakeWfe)
  );

  slpwk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .wfiReq(wfiReq), .wfeReq(wfeReq),
    .eventQ(eventQ), .eventNow(eventNow),
    .wakeWfi(wakeWfi), .wakeWfe(wakeWfe),
    .strobes(strobes), .coreClkEn(coreClkEn), .wakePulse(wakePulse)
  );

  assert_reset_awake_R1: assert property (@(posedge clk)
    !rstN |=> (coreClkEn && !wakePulse));

endmodule

// File: tb/sleep_wake_ctrl_test.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_test;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wfiReq = 0, wfeReq = 0, excTaken = 0, sevLocal = 0, evIn = 0;
  logic dbgReq = 0, dbgEn = 0, sevOnPend = 0, primask = 0;
  logic [N-1:0] irqPending = '0, irqEnable = '0, irqPreempt = '0;
  logic coreClkEn, wakePulse;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference model: 0 awake, 1 interrupt-wait, 2 event-wait
  int       mState = 0;
  bit       mLatch = 0;
  bit       mWake  = 0;
  logic [N-1:0] mMaskQ = '0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.NUM_IRQ(N)) uut (
    .clk(clk), .rstN(rstN), .wfiReq(wfiReq), .wfeReq(wfeReq),
    .irqPending(irqPending), .irqEnable(irqEnable), .irqPreempt(irqPreempt),
    .excTaken(excTaken), .sevLocal(sevLocal), .evIn(evIn),
    .dbgReq(dbgReq), .dbgEn(dbgEn), .sevOnPend(sevOnPend), .primask(primask),
    .coreClkEn(coreClkEn), .wakePulse(wakePulse)
  );

  function automatic bit refWakeWfi();
    return excTaken | (|(irqPending & irqEnable & irqPreempt)) | dbgReq;
  endfunction

  function automatic bit refWakeWfe();
    return excTaken | ((|(irqPending & irqEnable & irqPreempt)) & ~primask) |
           sevLocal | evIn | (dbgReq & dbgEn) |
           (sevOnPend & (|(irqPending & irqEnable & ~mMaskQ)));
  endfunction

  task automatic modelStep();
    bit ev;
    ev = sevLocal | evIn;
    mWake = 0;
    case (mState)
      0: begin
        if (wfiReq) begin mState = 1; if (ev) mLatch = 1; end
        else if (wfeReq) begin
          if (mLatch || ev) mLatch = 0; else mState = 2;
        end else if (ev) mLatch = 1;
      end
      1: begin
        if (ev) mLatch = 1;
        if (refWakeWfi()) begin mState = 0; mWake = 1; end
      end
      default: if (refWakeWfe()) begin mState = 0; mWake = 1; end
    endcase
    mMaskQ = irqPending & irqEnable;
  endtask

  task automatic compare(string tag);
    bit expEn;
    expEn = (mState == 0);
    nChecks++;
    if (coreClkEn !== expEn || wakePulse !== mWake) begin
      nFails++;
      $display("FAIL %s: coreClkEn=%0b wakePulse=%0b expected coreClkEn=%0b wakePulse=%0b at %0t",
               tag, coreClkEn, wakePulse, expEn, mWake, $time);
    end
  endtask

  task automatic tick(string tag);
    modelStep();
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic quiet();
    wfiReq = 0; wfeReq = 0; excTaken = 0; sevLocal = 0; evIn = 0; dbgReq = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset held");
    rstN = 1'b1;
    tick("R1 after reset");

    // event-wait sleep, debug gated by enable
    wfeReq = 1; tick("R3 enter event sleep"); quiet();
    tick("R3 stays asleep");
    dbgReq = 1; dbgEn = 0; tick("R5 debug disabled no wake");
    dbgEn = 1; tick("R4 debug wake"); quiet();
    tick("R9 pulse one cycle");

    // latched event makes event-wait fall through
    sevLocal = 1; tick("R8 latch event"); quiet();
    wfeReq = 1; tick("R2 fall through");
    tick("R3 second request sleeps"); quiet();
    evIn = 1; tick("R4 external event wake"); quiet();
    wfeReq = 1; sevLocal = 1; tick("R2 same-cycle event fall through"); quiet();

    // interrupt-wait with PRIMASK set
    primask = 1;
    wfiReq = 1; tick("R6 enter interrupt sleep"); quiet();
    sevLocal = 1; tick("R7 event no wake"); quiet();
    irqPending = 8'h01; irqEnable = 8'h01; irqPreempt = 8'h01;
    tick("R6 wake despite primask");
    irqPending = '0;
    wfeReq = 1; tick("R7 latched during sleep falls through"); quiet();

    // masked preemptable line in event sleep
    wfeReq = 1; tick("R3 enter"); quiet();
    irqPending = 8'h01; tick("R5 primask blocks preempt wake");
    primask = 0; tick("R4 preempt wake"); irqPending = '0;

    // newly pending detection
    irqPreempt = '0; irqEnable = 8'h06; irqPending = 8'h02; sevOnPend = 1;
    tick("R11 settle held line");
    wfeReq = 1; tick("R3 enter"); quiet();
    tick("R11 held line not new");
    irqPending = 8'h06; tick("R4 newly pending wake");
    irqPending = 8'h02; sevOnPend = 0; tick("R11 settle");
    wfeReq = 1; tick("R3 enter"); quiet();
    irqPending = 8'h06; tick("R5 new pending without sevOnPend");
    excTaken = 1; tick("R4 exception wake"); quiet();
    irqPending = '0; irqEnable = '0;

    // both requests and requests while asleep
    wfiReq = 1; wfeReq = 1; tick("R10 both selects interrupt sleep"); quiet();
    evIn = 1; tick("R10 event ignored in interrupt sleep"); quiet();
    wfeReq = 1; tick("R10 request ignored asleep"); quiet();
    dbgEn = 0; dbgReq = 1; tick("R6 debug wake without enable"); quiet();
    wfeReq = 1; tick("R8 latch from interrupt sleep consumed"); quiet();

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      wfiReq   = ($urandom_range(0, 9) == 0);
      wfeReq   = ($urandom_range(0, 5) == 0);
      excTaken = ($urandom_range(0, 24) == 0);
      sevLocal = ($urandom_range(0, 19) == 0);
      evIn     = ($urandom_range(0, 19) == 0);
      dbgReq   = ($urandom_range(0, 24) == 0);
      if ($urandom_range(0, 15) == 0) dbgEn     = ~dbgEn;
      if ($urandom_range(0, 15) == 0) sevOnPend = ~sevOnPend;
      if ($urandom_range(0, 15) == 0) primask   = ~primask;
      if ($urandom_range(0, 7) == 0) irqPending[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 15) == 0) irqEnable[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 15) == 0) irqPreempt[$urandom_range(0, N-1)] ^= 1'b1;
      tick("R4 R6 R8 random");
    end
    quiet();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule